// File: doc/BRIEF.md
# Eight-Channel Output Compare Unit with Master Override

The unit watches a 16-bit free-running count supplied from outside and compares it, every clock, against one 16-bit compare value per channel. When the count reaches a channel's value, the channel raises its flag. It can also request an interrupt. Its timer output then changes according to a two-bit action code for that channel: no change, toggle, drive low or drive high.

The last channel, index 7, acts as a master. It has a mask byte and a data byte. When channel 7 matches, every output selected by the mask is loaded with the matching data bit. This load wins over that output's own action in the same cycle. Pairing the master with another channel's own action gives two edges per count period, which is enough for pulse-width modulation.

An output that is neither driven by an action code nor selected by the mask shows a general-purpose port data bit instead of the timer value. Software programs the unit through a simple write port.

Top module: `oc_unit`

## Requirements
- R1: A channel compares only while its enable bit (register 8, bit n) is 1. A channel whose bit is 0 never sets its flag and never changes its output, even when the count equals its compare value. Compare values live at addresses 0 to 7, one per channel.
- R2: Each channel has an action code in register 9, bits [2n+1:2n]. The codes are 01 for toggle, 10 for drive low and 11 for drive high. The new level appears on the output one clock edge after the matching count is presented. With no match, the timer level does not change.
- R3: A match sets the channel's flag. Writing a word with bit n set to register 11 clears flag n. A 0 bit in that word leaves its flag alone. When a set and a clear fall in the same cycle, the set wins.
- R4: `irq_o` is 1 exactly when some flag is 1 and the same bit of the interrupt enable register (address 10) is 1.
- R5: On a channel 7 match, every output i with mask bit i = 1 (register 12) takes data bit i (register 13). Used with a second channel's own action, this gives two edges per count period.
- R6: When channel 7 and channel i match in the same cycle and mask bit i is 1, output i takes the channel 7 data bit, not the result of channel i's own action.
- R7: A match fires once for each new count value. While the count holds still, the output does not change again and a cleared flag is not set again.
- R8: An output whose action code is 00 and whose mask bit is 0 shows bit i of the port data register (address 14).
- R9: After reset, every register, flag and timer level is 0. All outputs and `irq_o` are therefore 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_i | input | 16 | Free-running count from outside the unit |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 16 | Register write data |
| pin_o | output | 8 | Channel output pins |
| flag_o | output | 8 | Per-channel match flags |
| irq_o | output | 1 | Interrupt request |

## Verification
Most internal state in this unit reaches the pins within one clock edge, so a fault in it shows up quickly. A timer level that is updated wrongly shows on `pin_o` right after the matching count. A wrong priority shows in the same cycle as a coincident channel 7 match. A flag with bad set or clear logic shows on `flag_o` and `irq_o` on the next edge. The one slower case is a stale last-count record. It only shows as a repeated toggle or a flag that sets itself again while the count holds still, so the bench holds the count for several cycles and watches for that.

// File: rtl/oc_pkg.sv
package oc_pkg;
    localparam int OC_CH = 8;
    localparam int OC_CW = 16;
    localparam int OC_AW = $clog2(OC_CH + 7);

    typedef enum logic [1:0] {
        ACT_NONE = 2'b00,
        ACT_TOG  = 2'b01,
        ACT_LOW  = 2'b10,
        ACT_HIGH = 2'b11
    } act_e;

    // control register offsets placed after the compare block
    localparam int OFS_DIR  = 0;
    localparam int OFS_ACT  = 1;
    localparam int OFS_IE   = 2;
    localparam int OFS_CLR  = 3;
    localparam int OFS_MASK = 4;
    localparam int OFS_DATA = 5;
    localparam int OFS_PORT = 6;
endpackage

// File: rtl/oc_regs.sv
module oc_regs
    import oc_pkg::*;
#(
    parameter int CH = OC_CH,
    parameter int CW = OC_CW,
    parameter int AW = OC_AW
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [AW-1:0]          wr_addr,
    input  logic [CW-1:0]          wr_data,
    input  logic [CH-1:0]          hit_i,
    output logic [CH-1:0][CW-1:0]  cmp_o,
    output logic [CH-1:0]          dir_o,
    output logic [2*CH-1:0]        act_o,
    output logic [CH-1:0]          ie_o,
    output logic [CH-1:0]          mask_o,
    output logic [CH-1:0]          data_o,
    output logic [CH-1:0]          port_o,
    output logic [CH-1:0]          flag_o
);
    localparam logic [AW-1:0] A_DIR  = AW'(CH + OFS_DIR);
    localparam logic [AW-1:0] A_ACT  = AW'(CH + OFS_ACT);
    localparam logic [AW-1:0] A_IE   = AW'(CH + OFS_IE);
    localparam logic [AW-1:0] A_CLR  = AW'(CH + OFS_CLR);
    localparam logic [AW-1:0] A_MASK = AW'(CH + OFS_MASK);
    localparam logic [AW-1:0] A_DATA = AW'(CH + OFS_DATA);
    localparam logic [AW-1:0] A_PORT = AW'(CH + OFS_PORT);

    typedef struct packed {
        logic [CH-1:0][CW-1:0] cmp;
        logic [CH-1:0]         dir;
        logic [2*CH-1:0]       act;
        logic [CH-1:0]         ie;
        logic [CH-1:0]         mask;
        logic [CH-1:0]         data;
        logic [CH-1:0]         port;
        logic [CH-1:0]         flg;
    } reg_t;

    reg_t r_d, r_q;
    logic [CH-1:0] clr;

    always_comb begin
        r_d = r_q;
        clr = '0;
        if (wr_en) begin
            for (int k = 0; k < CH; k++) begin
                if (wr_addr == AW'(k)) r_d.cmp[k] = wr_data;
            end
            if (wr_addr == A_DIR)  r_d.dir  = wr_data[CH-1:0];
            if (wr_addr == A_ACT)  r_d.act  = wr_data[2*CH-1:0];
            if (wr_addr == A_IE)   r_d.ie   = wr_data[CH-1:0];
            if (wr_addr == A_MASK) r_d.mask = wr_data[CH-1:0];
            if (wr_addr == A_DATA) r_d.data = wr_data[CH-1:0];
            if (wr_addr == A_PORT) r_d.port = wr_data[CH-1:0];
            if (wr_addr == A_CLR)  clr      = wr_data[CH-1:0];
        end
        // a new match outranks a clear in the same cycle
        r_d.flg = (r_q.flg & ~clr) | hit_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign cmp_o  = r_q.cmp;
    assign dir_o  = r_q.dir;
    assign act_o  = r_q.act;
    assign ie_o   = r_q.ie;
    assign mask_o = r_q.mask;
    assign data_o = r_q.data;
    assign port_o = r_q.port;
    assign flag_o = r_q.flg;
endmodule

// File: rtl/oc_match.sv
module oc_match #(
    parameter int CH = 8,
    parameter int CW = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [CW-1:0]          cnt_i,
    input  logic [CH-1:0][CW-1:0]  cmp_i,
    input  logic [CH-1:0]          dir_i,
    output logic [CH-1:0]          hit_o
);
    typedef struct packed {
        logic [CW-1:0] last;
        logic          seen;
    } mst_t;

    mst_t m_d, m_q;
    logic fresh;

    always_comb begin
        m_d      = m_q;
        m_d.last = cnt_i;
        m_d.seen = 1'b1;
        fresh    = !m_q.seen || (cnt_i != m_q.last);
    end

    for (genvar g = 0; g < CH; g++) begin : g_cmp
        assign hit_o[g] = dir_i[g] && fresh && (cnt_i == cmp_i[g]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) m_q <= '0;
        else        m_q <= m_d;
    end
endmodule

// File: rtl/oc_drive.sv
module oc_drive
    import oc_pkg::*;
#(
    parameter int CH = OC_CH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CH-1:0]     hit_i,
    input  logic [2*CH-1:0]   act_i,
    input  logic [CH-1:0]     mask_i,
    input  logic [CH-1:0]     data_i,
    input  logic [CH-1:0]     port_i,
    output logic [CH-1:0]     tmr_o,
    output logic [CH-1:0]     pin_o
);
    localparam int MST = CH - 1;

    typedef struct packed {
        logic [CH-1:0] tmr;
    } dst_t;

    dst_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        for (int i = 0; i < CH; i++) begin
            if (hit_i[i]) begin
                case (act_e'(act_i[2*i +: 2]))
                    ACT_TOG:  s_d.tmr[i] = ~s_q.tmr[i];
                    ACT_LOW:  s_d.tmr[i] = 1'b0;
                    ACT_HIGH: s_d.tmr[i] = 1'b1;
                    default:  s_d.tmr[i] = s_q.tmr[i];
                endcase
            end
            // master load is applied last so it wins
            if (hit_i[MST] && mask_i[i]) s_d.tmr[i] = data_i[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    for (genvar g = 0; g < CH; g++) begin : g_pin
        assign pin_o[g] = (act_i[2*g +: 2] != 2'b00 || mask_i[g]) ? s_q.tmr[g] : port_i[g];
    end

    assign tmr_o = s_q.tmr;
endmodule

// File: rtl/oc_unit.sv
module oc_unit
    import oc_pkg::*;
#(
    parameter int CH = OC_CH,
    parameter int CW = OC_CW,
    parameter int AW = OC_AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] cnt_i,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [CW-1:0] wr_data,
    output logic [CH-1:0] pin_o,
    output logic [CH-1:0] flag_o,
    output logic          irq_o
);
    logic [CH-1:0][CW-1:0] cmp;
    logic [CH-1:0]         dir, ie, mask, data, port, hit, tmr;
    logic [2*CH-1:0]       act;

    oc_regs #(.CH(CH), .CW(CW), .AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .hit_i(hit), .cmp_o(cmp), .dir_o(dir),
        .act_o(act), .ie_o(ie), .mask_o(mask), .data_o(data),
        .port_o(port), .flag_o(flag_o)
    );

    oc_match #(.CH(CH), .CW(CW)) u_match (
        .clk(clk), .rst_n(rst_n), .cnt_i(cnt_i), .cmp_i(cmp),
        .dir_i(dir), .hit_o(hit)
    );

    oc_drive #(.CH(CH)) u_drive (
        .clk(clk), .rst_n(rst_n), .hit_i(hit), .act_i(act),
        .mask_i(mask), .data_i(data), .port_i(port),
        .tmr_o(tmr), .pin_o(pin_o)
    );

    assign irq_o = |(flag_o & ie);
endmodule

// File: rtl/oc_unit_chk.sv
module oc_unit_chk #(
    parameter int CH = 8,
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic [CW-1:0] cnt_i,
    input logic [CH-1:0] hit,
    input logic [CH-1:0] tmr,
    input logic [CH-1:0] mask,
    input logic [CH-1:0] data,
    input logic [CH-1:0] flag_o,
    input logic          irq_o
);
    logic armed_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    // R4: a request needs a raised flag behind it
    p_irq_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (|flag_o));

    // R3: a flag only rises after a match
    p_flag_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && (|(flag_o & ~$past(flag_o))) |-> (|$past(hit)));

    // R7: a held count never matches twice in a row
    p_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && (|$past(hit)) && $stable(cnt_i) |-> !(|hit));

    // R5: master match loads masked bits from data
    p_master_r5: assert property (@(posedge clk) disable iff (!rst_n)
        hit[CH-1] |=> ((tmr & $past(mask)) == ($past(data) & $past(mask))));

    // R2: timer levels change only on a match
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(|hit) |=> $stable(tmr));
endmodule

bind oc_unit oc_unit_chk #(.CH(CH), .CW(CW)) i_oc_unit_chk (
    .clk(clk), .rst_n(rst_n), .cnt_i(cnt_i), .hit(hit), .tmr(tmr),
    .mask(mask), .data(data), .flag_o(flag_o), .irq_o(irq_o)
);

// File: tb/test_oc_unit.sv
module test_oc_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cnt_i = 16'd100;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [7:0]  pin_o, flag_o;
    logic        irq_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    oc_unit i_oc_unit (
        .clk(clk), .rst_n(rst_n), .cnt_i(cnt_i), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .pin_o(pin_o),
        .flag_o(flag_o), .irq_o(irq_o)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic step(input logic [15:0] v);
        cnt_i = v;
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R9 pins", 16'(pin_o), 16'h0);
        chk("R9 flags", 16'(flag_o), 16'h0);
        chk("R9 irq", 16'(irq_o), 16'h0);
    endtask

    task automatic t_actions();
        wr(4'd1, 16'd10); wr(4'd2, 16'd20); wr(4'd3, 16'd30);
        wr(4'd9, 16'h00F4); wr(4'd8, 16'h000E);
        step(16'd10); chk("R2 toggle up", 16'(pin_o[1]), 16'h1);
        step(16'd11); chk("R2 hold", 16'(pin_o[1]), 16'h1);
        step(16'd10); chk("R2 toggle down", 16'(pin_o[1]), 16'h0);
        step(16'd30); chk("R2 high", 16'(pin_o[3]), 16'h1);
        step(16'd20); chk("R2 high ch2", 16'(pin_o[2]), 16'h1);
        wr(4'd9, 16'h00E4);
        step(16'd21); step(16'd20);
        chk("R2 low", 16'(pin_o[2]), 16'h0);
        chk("R2 pins", 16'(pin_o), 16'h0008);
        chk("R3 flags set", 16'(flag_o), 16'h000E);
    endtask

    task automatic t_flags();
        wr(4'd11, 16'h0002); chk("R3 clear one", 16'(flag_o), 16'h000C);
        wr(4'd11, 16'h0000); chk("R3 zero no effect", 16'(flag_o), 16'h000C);
        wr(4'd10, 16'h0008); chk("R4 irq on", 16'(irq_o), 16'h1);
        wr(4'd10, 16'h0001); chk("R4 irq off", 16'(irq_o), 16'h0);
        cnt_i = 16'd10;
        wr(4'd11, 16'h0002);
        chk("R3 set wins", 16'(flag_o), 16'h000E);
        wr(4'd11, 16'h00FF); chk("R3 clear all", 16'(flag_o), 16'h0000);
    endtask

    task automatic t_master();
        wr(4'd0, 16'd40); wr(4'd7, 16'd50);
        wr(4'd9, 16'h00E6); wr(4'd8, 16'h008F);
        wr(4'd12, 16'h0011); wr(4'd13, 16'h0001);
        step(16'd50);
        chk("R5 master load", 16'(pin_o), 16'h000B);
        chk("R5 flag7", 16'(flag_o), 16'h0080);
        step(16'd40); chk("R5 pwm low edge", 16'(pin_o[0]), 16'h0);
        step(16'd50); chk("R5 pwm high edge", 16'(pin_o[0]), 16'h1);
        wr(4'd13, 16'h0010);
        step(16'd51); step(16'd50);
        chk("R5 new data", 16'(pin_o), 16'h001A);
    endtask

    task automatic t_priority();
        wr(4'd1, 16'd60); wr(4'd7, 16'd60);
        wr(4'd12, 16'h0002); wr(4'd13, 16'h0002);
        step(16'd60); chk("R6 master over toggle", 16'(pin_o[1]), 16'h1);
        step(16'd61); step(16'd60);
        chk("R6 master over toggle again", 16'(pin_o[1]), 16'h1);
        chk("R6 pins", 16'(pin_o), 16'h000A);
    endtask

    task automatic t_stopped();
        wr(4'd3, 16'd70); wr(4'd9, 16'h0066); wr(4'd11, 16'h00FF);
        step(16'd70);
        chk("R7 first toggle", 16'(pin_o[3]), 16'h0);
        chk("R7 flag", 16'(flag_o), 16'h0008);
        repeat (3) @(negedge clk);
        chk("R7 no retoggle", 16'(pin_o[3]), 16'h0);
        wr(4'd11, 16'h0008);
        repeat (3) @(negedge clk);
        chk("R7 no reflag", 16'(flag_o), 16'h0000);
    endtask

    task automatic t_dir_off();
        wr(4'd5, 16'd80); wr(4'd9, 16'h0C66);
        step(16'd80);
        chk("R1 disabled pin", 16'(pin_o[5]), 16'h0);
        chk("R1 disabled flag", 16'(flag_o), 16'h0000);
    endtask

    task automatic t_port();
        wr(4'd14, 16'h0040);
        chk("R8 port shown", 16'(pin_o[6]), 16'h1);
        wr(4'd14, 16'h0060);
        chk("R8 connected ignores port", 16'(pin_o & 8'h60), 16'h0040);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_actions();
        t_flags();
        t_master();
        t_priority();
        t_stopped();
        t_dir_off();
        t_port();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule